// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 18-bit buses, A and B, with one independent storage stage per direction. Each stage has three modes. It is transparent while its latch-enable input is high. It holds its stored word while latch-enable is low and its direction clock stays steady. It captures the incoming word on a rising edge of its direction clock while latch-enable is low.

The direction clocks are ordinary inputs. The block samples them with the system clock `clk` and detects rising edges synchronously. A captured word therefore appears on the output one `clk` cycle after the edge is sampled.

Each output side is presented as a data vector plus one drive-enable bit, so that a pad ring can build the real three-state driver. The A-to-B enable is active high and the B-to-A enable is active low. With the `HOLD_EN` parameter set, an input bus whose driver has let go is read as the last word seen while it was driven. This models the bus-hold cells on the inputs. An active-low asynchronous reset clears all stored state.

Top module: `regbus_xcvr`

## Requirements
- R1: After `rst_n` is asserted low, both stored words are zero, so `bOut` and `aOut` read 0 while both latch enables are low.
- R2: While `leAB` is 1, `bOut` equals the effective A input bit for bit, in the same cycle and without inversion.
- R3: While `leAB` is 0 and `clkAB` shows no rising edge, `bOut` keeps its value, even when `aIn` changes or `clkAB` falls.
- R4: While `leAB` is 0, a rising edge of `clkAB` that is sampled at a `clk` edge loads the effective A input at that edge into storage. `bOut` shows the loaded word from then on. A `clkAB` level that stays high does not load again.
- R5: When `leAB` falls, `bOut` keeps the last word that was passed transparently and sampled at a `clk` edge, with no cycle of a different value.
- R6: `bOutEn` is 1 exactly when `oeAB` is 1.
- R7: `aOutEn` is 1 exactly when `oeBAn` is 0.
- R8: The B-to-A path obeys the rules of R2 to R5, using `leBA`, `clkBA`, `bIn` and `aOut`, and is independent of the A-to-B controls.
- R9: With `HOLD_EN`=1, a bus whose driven flag (`aInDriven` or `bInDriven`) is 0 is read as the last word sampled while that flag was 1. This applies in transparent mode and in capture mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the direction clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| aIn | input | 18 | Word arriving from bus A |
| aInDriven | input | 1 | 1 while an external driver is on bus A |
| bIn | input | 18 | Word arriving from bus B |
| bInDriven | input | 1 | 1 while an external driver is on bus B |
| leAB | input | 1 | A-to-B latch enable, transparent when 1 |
| clkAB | input | 1 | A-to-B capture clock |
| oeAB | input | 1 | A-to-B output enable, active high |
| leBA | input | 1 | B-to-A latch enable, transparent when 1 |
| clkBA | input | 1 | B-to-A capture clock |
| oeBAn | input | 1 | B-to-A output enable, active low |
| bOut | output | 18 | Data presented toward bus B |
| bOutEn | output | 1 | Drive enable for bus B |
| aOut | output | 18 | Data presented toward bus A |
| aOutEn | output | 1 | Drive enable for bus A |

## Verification
The hardest case to reach is the seam between modes. The bench must show that `bOut` holds the transparent word exactly when `leAB` falls in the same cycle as `aIn` changes, and that a direction clock held high yields one capture and not one per `clk` cycle. The stimulus sets up the transparent word and lets one `clk` edge sample it. On the next falling edge of `clk` it drops the latch enable and changes the input together, then checks the output before the next rising edge. The bus-hold case is reached the same way: a word is sampled while driven, and the driven flag is then released together with a different word on the input.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;
  typedef struct packed {
    logic pass;
    logic load;
    logic drive;
  } dirStrobe_t;
endpackage

// File: rtl/regbus_xcvr_ctrl.sv
module regbus_xcvr_ctrl
  import regbus_xcvr_pkg::*;
#(
  parameter int NUM_DIR = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_DIR-1:0]     latchEn,
  input  logic [NUM_DIR-1:0]     edgeClk,
  input  logic [NUM_DIR-1:0]     outActive,
  output dirStrobe_t [NUM_DIR-1:0] strobe
);
  logic [NUM_DIR-1:0] prevClk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevClk <= '0;
    else        prevClk <= edgeClk;
  end

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    logic rise;
    assign rise = edgeClk[d] & ~prevClk[d];
    always_comb begin
      strobe[d].pass  = latchEn[d];
      strobe[d].load  = latchEn[d] | rise;
      strobe[d].drive = outActive[d];
    end
  end
endmodule

// File: rtl/regbus_xcvr_dp.sv
module regbus_xcvr_dp
  import regbus_xcvr_pkg::*;
#(
  parameter int WIDTH   = 18,
  parameter int NUM_DIR = 2,
  parameter bit HOLD_EN = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_DIR-1:0][WIDTH-1:0]     dataIn,
  input  logic [NUM_DIR-1:0]                inDriven,
  input  dirStrobe_t [NUM_DIR-1:0]          strobe,
  output logic [NUM_DIR-1:0][WIDTH-1:0]     dataOut
);
  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    logic [WIDTH-1:0] effIn;
    logic [WIDTH-1:0] stored;

    if (HOLD_EN) begin : g_hold
      logic [WIDTH-1:0] heldIn;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           heldIn <= '0;
        else if (inDriven[d]) heldIn <= dataIn[d];
      end
      assign effIn = inDriven[d] ? dataIn[d] : heldIn;
    end else begin : g_nohold
      assign effIn = dataIn[d];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              stored <= '0;
      else if (strobe[d].load) stored <= effIn;
    end

    assign dataOut[d] = strobe[d].pass ? effIn : stored;
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_xcvr_pkg::*;
#(
  parameter int WIDTH   = 18,
  parameter bit HOLD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] aIn,
  input  logic             aInDriven,
  input  logic [WIDTH-1:0] bIn,
  input  logic             bInDriven,
  input  logic             leAB,
  input  logic             clkAB,
  input  logic             oeAB,
  input  logic             leBA,
  input  logic             clkBA,
  input  logic             oeBAn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOutEn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOutEn
);
  localparam int NUM_DIR = 2;
  localparam int DIR_AB  = 0;
  localparam int DIR_BA  = 1;

  dirStrobe_t [NUM_DIR-1:0]      strobe;
  logic [NUM_DIR-1:0][WIDTH-1:0] dpIn;
  logic [NUM_DIR-1:0][WIDTH-1:0] dpOut;

  assign dpIn[DIR_AB] = aIn;
  assign dpIn[DIR_BA] = bIn;

  regbus_xcvr_ctrl #(.NUM_DIR(NUM_DIR)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .latchEn   ({leBA, leAB}),
    .edgeClk   ({clkBA, clkAB}),
    .outActive ({~oeBAn, oeAB}),
    .strobe    (strobe)
  );

  regbus_xcvr_dp #(.WIDTH(WIDTH), .NUM_DIR(NUM_DIR), .HOLD_EN(HOLD_EN)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dataIn   (dpIn),
    .inDriven ({bInDriven, aInDriven}),
    .strobe   (strobe),
    .dataOut  (dpOut)
  );

  assign bOut   = dpOut[DIR_AB];
  assign aOut   = dpOut[DIR_BA];
  assign bOutEn = strobe[DIR_AB].drive;
  assign aOutEn = strobe[DIR_BA].drive;
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] aIn,
  input logic             aInDriven,
  input logic [WIDTH-1:0] bIn,
  input logic             bInDriven,
  input logic             leAB,
  input logic             clkAB,
  input logic             oeAB,
  input logic             leBA,
  input logic             clkBA,
  input logic             oeBAn,
  input logic [WIDTH-1:0] bOut,
  input logic             bOutEn,
  input logic [WIDTH-1:0] aOut,
  input logic             aOutEn
);
  AST_AB_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    (leAB && aInDriven) |-> (bOut == aIn)); // R2

  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!leAB && !clkAB) |=> (leAB || $stable(bOut))); // R3

  AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!leAB && clkAB && !$past(clkAB) && aInDriven) |=> (leAB || bOut == $past(aIn))); // R4

  AST_AB_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    oeAB |-> bOutEn); // R6

  AST_BA_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    oeBAn |-> !aOutEn); // R7

  AST_BA_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    (leBA && bInDriven) |-> (aOut == bIn)); // R8

  AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!leBA && !clkBA) |=> (leBA || $stable(aOut))); // R8
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .aIn(aIn), .aInDriven(aInDriven), .bIn(bIn),
  .bInDriven(bInDriven), .leAB(leAB), .clkAB(clkAB), .oeAB(oeAB),
  .leBA(leBA), .clkBA(clkBA), .oeBAn(oeBAn), .bOut(bOut), .bOutEn(bOutEn),
  .aOut(aOut), .aOutEn(aOutEn)
);

// File: tb/regbus_xcvr_tb_top.sv
module regbus_xcvr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic aInDriven = 1'b1, bInDriven = 1'b1;
  logic leAB = 1'b0, clkAB = 1'b0, oeAB = 1'b0;
  logic leBA = 1'b0, clkBA = 1'b0, oeBAn = 1'b1;
  logic [W-1:0] bOut, aOut;
  logic bOutEn, aOutEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regbus_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .aIn(aIn), .aInDriven(aInDriven), .bIn(bIn),
    .bInDriven(bInDriven), .leAB(leAB), .clkAB(clkAB), .oeAB(oeAB),
    .leBA(leBA), .clkBA(clkBA), .oeBAn(oeBAn), .bOut(bOut), .bOutEn(bOutEn),
    .aOut(aOut), .aOutEn(aOutEn)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic tReset();
    rst_n = 1'b0;
    repeat (2) settle();
    rst_n = 1'b1;
    settle();
    chk(bOut == '0, "R1 bOut after reset", 32'(bOut), 0);
    chk(aOut == '0, "R1 aOut after reset", 32'(aOut), 0);
  endtask

  task automatic tTransparentAB();
    leAB = 1'b1; aIn = 18'h2A5C3; #1;
    chk(bOut == 18'h2A5C3, "R2 transparent word 1", 32'(bOut), 32'h2A5C3);
    settle(); aIn = 18'h15A3C; #1;
    chk(bOut == 18'h15A3C, "R2 transparent word 2", 32'(bOut), 32'h15A3C);
    settle();
  endtask

  task automatic tLeFallAB();
    leAB = 1'b1; aIn = 18'h0BEEF;
    settle();
    leAB = 1'b0; aIn = 18'h31111; #1;
    chk(bOut == 18'h0BEEF, "R5 hold at latch-enable fall", 32'(bOut), 32'h0BEEF);
    settle();
    chk(bOut == 18'h0BEEF, "R3 hold next cycle", 32'(bOut), 32'h0BEEF);
  endtask

  task automatic tCaptureAB();
    leAB = 1'b0; clkAB = 1'b0; settle();
    aIn = 18'h1C0DE; clkAB = 1'b1; #1;
    chk(bOut == 18'h0BEEF, "R4 no change before edge sampled", 32'(bOut), 32'h0BEEF);
    settle();
    chk(bOut == 18'h1C0DE, "R4 captured on rising edge", 32'(bOut), 32'h1C0DE);
    aIn = 18'h22222; settle();
    chk(bOut == 18'h1C0DE, "R4 level high no recapture", 32'(bOut), 32'h1C0DE);
    clkAB = 1'b0; aIn = 18'h33333; settle();
    chk(bOut == 18'h1C0DE, "R3 falling edge ignored", 32'(bOut), 32'h1C0DE);
  endtask

  task automatic tEnables();
    oeAB = 1'b1; oeBAn = 1'b1; #1;
    chk(bOutEn == 1'b1, "R6 oeAB high", 32'(bOutEn), 1);
    chk(aOutEn == 1'b0, "R7 oeBAn high", 32'(aOutEn), 0);
    oeAB = 1'b0; oeBAn = 1'b0; #1;
    chk(bOutEn == 1'b0, "R6 oeAB low", 32'(bOutEn), 0);
    chk(aOutEn == 1'b1, "R7 oeBAn low", 32'(aOutEn), 1);
    settle();
  endtask

  task automatic tBtoA();
    leBA = 1'b1; bIn = 18'h2F0F0; #1;
    chk(aOut == 18'h2F0F0, "R8 transparent", 32'(aOut), 32'h2F0F0);
    chk(bOut == 18'h1C0DE, "R8 A-to-B untouched", 32'(bOut), 32'h1C0DE);
    settle();
    leBA = 1'b0; bIn = 18'h00001; #1;
    chk(aOut == 18'h2F0F0, "R8 hold at latch-enable fall", 32'(aOut), 32'h2F0F0);
    settle();
    clkBA = 1'b1; bIn = 18'h3ABCD; settle();
    chk(aOut == 18'h3ABCD, "R8 capture on rising edge", 32'(aOut), 32'h3ABCD);
    bIn = 18'h12345; settle();
    chk(aOut == 18'h3ABCD, "R8 level high no recapture", 32'(aOut), 32'h3ABCD);
    clkBA = 1'b0; settle();
  endtask

  task automatic tBusHold();
    aInDriven = 1'b1; aIn = 18'h26B1D; leAB = 1'b1; settle();
    aInDriven = 1'b0; aIn = 18'h00F00; #1;
    chk(bOut == 18'h26B1D, "R9 undriven transparent reads held", 32'(bOut), 32'h26B1D);
    leAB = 1'b0; settle();
    clkAB = 1'b0; settle();
    leAB = 1'b0; settle();
    aIn = 18'h0DEAD; clkAB = 1'b1; settle();
    chk(bOut == 18'h26B1D, "R9 undriven capture reads held", 32'(bOut), 32'h26B1D);
    aInDriven = 1'b1; clkAB = 1'b0; settle();
  endtask

  initial begin
    tReset();
    tTransparentAB();
    tLeFallAB();
    tCaptureAB();
    tEnables();
    tBtoA();
    tBusHold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule